// File: doc/BRIEF.md
# Host-Adapter Mailbox Doorbell Controller

This block holds the two status registers that coordinate four shared-memory mailboxes between a host processor and an adapter controller. The mailboxes are the host request block, the adapter status block, the adapter request block and the host status block. The host rings doorbells by OR-ing bits into the doorbell register. The adapter controller sees those bits on `dbell_pend` and acknowledges each one with a clear pulse.

In the other direction, the adapter reports completions through one-cycle event inputs. Each event sets a bit in the host status register, and `host_irq` is raised while any of those bits is set. The host acknowledges a completion by AND-ing a mask into the host status register.

Two doorbell bits are deferred requests. The host sets one when it wants to reuse a mailbox that is still busy. The block then raises the matching host notification when the mailbox becomes free, and drops the deferred request in the same cycle.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, `host_stat` and `dbell_pend` are 0x00 and `host_irq` is low.
- R2: When `host_or_en` is high, bits 5..0 of `host_or_mask` are OR-ed into `dbell_pend` at the next edge. Earlier pending bits are kept, and mask bits 7..6 are ignored. Doorbell bit meanings are:
  - bit 5: a new command is in the host request block
  - bit 4: a response is in the adapter status block
  - bit 3: the host wants the request block once the pending command completes
  - bit 2: the host wants the adapter status block once it has been read
  - bit 1: the adapter request block is free
  - bit 0: the host status block is free
- R3: A high bit in `dbell_done` clears the same `dbell_pend` bit at the next edge. If the host ORs the same bit in that cycle, the bit ends up set.
- R4: A pulse on `adp_evt[6]`, `[5]`, `[3]`, `[2]` or `[1]` sets the same `host_stat` bit at the next edge. The meanings are:
  - 6: adapter closed after a fault
  - 5: request accepted
  - 3: command posted for the host
  - 2: response posted in the host status block
  - 1: bridge forward done
- R5: A pulse on `adp_evt[4]` (adapter status block read) sets `host_stat[4]` only if `dbell_pend[2]` is set or `resp_err` is high in that cycle. Whether or not bit 4 is set, the pulse clears `dbell_pend[2]`.
- R6: A pulse on `adp_evt[5]` while `dbell_pend[3]` is set raises `host_stat[5]` and clears `dbell_pend[3]` at the same edge.
- R7: When `host_and_en` is high, `host_stat` is AND-ed with `host_and_mask` at the next edge. An event setting a bit in that same cycle wins over the clear.
- R8: `host_stat[0]`, `host_stat[7]`, `dbell_pend[7:6]` are always 0; `adp_evt[0]` and `adp_evt[7]` have no effect. `host_irq` is high exactly while any of `host_stat[6:1]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_or_en | input | 1 | Host OR access to doorbell register |
| host_or_mask | input | 8 | Bits to set in doorbell register |
| host_and_en | input | 1 | Host AND access to host status register |
| host_and_mask | input | 8 | AND mask for host status register |
| dbell_done | input | 8 | Adapter clear pulses for doorbell bits |
| adp_evt | input | 8 | Adapter one-cycle completion events |
| resp_err | input | 1 | Adapter found an error in the host's response |
| host_stat | output | 8 | Host status register |
| dbell_pend | output | 8 | Doorbell register (pending to adapter) |
| host_irq | output | 1 | Level interrupt to host |

## Verification
Both registers update at the first clock edge after an access or event, so every register result is due exactly one cycle after its stimulus. `host_irq` is decoded from `host_stat` with no further register, so it is due in that same cycle. The bench applies each stimulus on a falling edge, which lets one rising edge update the registers. It then samples at the following falling edge and drops the stimulus, so no result is ever read in the cycle it is launched.

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_or_en,
  input  logic [W-1:0] host_or_mask,
  input  logic         host_and_en,
  input  logic [W-1:0] host_and_mask,
  input  logic [W-1:0] dbell_done,
  input  logic [W-1:0] adp_evt,
  input  logic         resp_err,
  output logic [W-1:0] host_stat,
  output logic [W-1:0] dbell_pend,
  output logic         host_irq
);
  localparam logic [W-1:0] DB_LIVE = W'('h3F);
  localparam logic [W-1:0] HS_LIVE = W'('h7E);
  localparam int B_REQ_DONE = 5;
  localparam int B_BLK_READ = 4;
  localparam int B_WAIT_REQ = 3;
  localparam int B_WAIT_BLK = 2;

  logic [W-1:0] db_q, hs_q, db_set, db_auto, hs_set, hs_keep;
  logic         blk_note;

  assign blk_note = adp_evt[B_BLK_READ] & (db_q[B_WAIT_BLK] | resp_err);
  assign db_set   = host_or_en ? (host_or_mask & DB_LIVE) : '0;

  always_comb begin
    db_auto = '0;
    db_auto[B_WAIT_REQ] = adp_evt[B_REQ_DONE];
    db_auto[B_WAIT_BLK] = adp_evt[B_BLK_READ];
    hs_set = adp_evt & HS_LIVE;
    hs_set[B_BLK_READ] = blk_note;
  end

  assign hs_keep = host_and_en ? host_and_mask : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q <= '0;
      hs_q <= '0;
    end else begin
      db_q <= (db_q & ~dbell_done & ~db_auto) | db_set;
      hs_q <= (hs_q & hs_keep) | hs_set;
    end
  end

  assign dbell_pend = db_q;
  assign host_stat  = hs_q;
  assign host_irq   = |(hs_q & HS_LIVE);
endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_or_en,
  input logic [W-1:0] host_or_mask,
  input logic         host_and_en,
  input logic [W-1:0] host_and_mask,
  input logic [W-1:0] dbell_done,
  input logic [W-1:0] adp_evt,
  input logic         resp_err,
  input logic [W-1:0] host_stat,
  input logic [W-1:0] dbell_pend,
  input logic         host_irq
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (host_stat == '0 && dbell_pend == '0));

  p_or_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_or_en |=> ((dbell_pend & $past(host_or_mask & W'('h3F))) == $past(host_or_mask & W'('h3F))));

  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbell_done[5] && !(host_or_en && host_or_mask[5])) |=> !dbell_pend[5]);

  p_fault_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adp_evt[6] |=> host_stat[6]);

  p_blk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adp_evt[4] && !dbell_pend[2] && !resp_err && !host_stat[4]) |=> !host_stat[4]);

  p_req_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adp_evt[5] && dbell_pend[3] && !(host_or_en && host_or_mask[3])) |=> (host_stat[5] && !dbell_pend[3]));

  p_and_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_and_en && !host_and_mask[1] && !adp_evt[1]) |=> !host_stat[1]);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_stat[0] && !host_stat[7] && dbell_pend[7:6] == 2'b00));

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> (host_stat != '0));
endmodule

bind mbox_doorbell mbox_doorbell_chk #(.W(W)) chk_i (.*);

// File: tb/mbox_doorbell_tb.sv
`timescale 1ns/1ps
module mbox_doorbell_tb_top;
  logic clk = 0, rst_n = 0;
  logic host_or_en = 0, host_and_en = 0, resp_err = 0;
  logic [7:0] host_or_mask = 0, host_and_mask = 0, dbell_done = 0, adp_evt = 0;
  logic [7:0] host_stat, dbell_pend;
  logic host_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_doorbell dut_i (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(logic oe, logic [7:0] om, logic ae, logic [7:0] am,
                      logic [7:0] dd, logic [7:0] ev, logic er);
    host_or_en = oe; host_or_mask = om; host_and_en = ae; host_and_mask = am;
    dbell_done = dd; adp_evt = ev; resp_err = er;
    @(negedge clk);
    host_or_en = 0; host_or_mask = 0; host_and_en = 0; host_and_mask = 0;
    dbell_done = 0; adp_evt = 0; resp_err = 0;
  endtask

  task automatic clear_all();
    step(0, 0, 1, 8'h00, 8'hFF, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 host_stat", host_stat, 8'h00);
    chk("R1 dbell_pend", dbell_pend, 8'h00);
    chk("R1 irq", {7'd0, host_irq}, 8'h00);
  endtask

  task automatic t_or();
    step(1, 8'hFF, 0, 0, 0, 0, 0);
    chk("R2 or all, top bits ignored", dbell_pend, 8'h3F);
    clear_all();
    step(1, 8'h20, 0, 0, 0, 0, 0);
    step(1, 8'h10, 0, 0, 0, 0, 0);
    chk("R2 accumulate", dbell_pend, 8'h30);
  endtask

  task automatic t_done();
    step(0, 0, 0, 0, 8'h10, 0, 0);
    chk("R3 clear pulse", dbell_pend, 8'h20);
    step(1, 8'h20, 0, 0, 8'h20, 0, 0);
    chk("R3 set wins", dbell_pend, 8'h20);
    step(0, 0, 0, 0, 8'h3F, 0, 0);
    chk("R3 clear all", dbell_pend, 8'h00);
  endtask

  task automatic t_events();
    step(0, 0, 0, 0, 0, 8'h40, 0);
    chk("R4 fault event", host_stat, 8'h40);
    chk("R8 irq high", {7'd0, host_irq}, 8'h01);
    step(0, 0, 1, 8'h00, 0, 0, 0);
    chk("R7 and clear", host_stat, 8'h00);
    chk("R8 irq low", {7'd0, host_irq}, 8'h00);
    step(0, 0, 0, 0, 0, 8'h2E, 0);
    chk("R4 multi events", host_stat, 8'h2E);
    step(0, 0, 1, 8'h00, 0, 8'h04, 0);
    chk("R7 set beats and", host_stat, 8'h04);
    clear_all();
    step(0, 0, 0, 0, 0, 8'h81, 0);
    chk("R8 ignored event bits", host_stat, 8'h00);
    chk("R8 irq stays low", {7'd0, host_irq}, 8'h00);
  endtask

  task automatic t_blk();
    step(0, 0, 0, 0, 0, 8'h10, 0);
    chk("R5 no request no note", host_stat, 8'h00);
    step(1, 8'h04, 0, 0, 0, 0, 0);
    chk("R5 deferred set", dbell_pend, 8'h04);
    step(0, 0, 0, 0, 0, 8'h10, 0);
    chk("R5 note raised", host_stat, 8'h10);
    chk("R5 deferred dropped", dbell_pend, 8'h00);
    clear_all();
    step(0, 0, 0, 0, 0, 8'h10, 1);
    chk("R5 error path", host_stat, 8'h10);
    clear_all();
  endtask

  task automatic t_req();
    step(1, 8'h08, 0, 0, 0, 0, 0);
    chk("R6 deferred set", dbell_pend, 8'h08);
    step(0, 0, 0, 0, 0, 8'h20, 0);
    chk("R6 completion", host_stat, 8'h20);
    chk("R6 deferred dropped", dbell_pend, 8'h00);
    clear_all();
    step(1, 8'h01, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 8'h20, 0);
    chk("R6 other bits kept", dbell_pend, 8'h01);
    chk("R4 accepted without wait", host_stat, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_or();
    t_done();
    t_events();
    t_blk();
    t_req();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule